// File: doc/BRIEF.md
# Sweep-Driven Indexed Gather Unit

The unit fills a bank of destination registers. Each register picks one element of a short source vector, and a per-destination index chooses which element. A full crossbar would give every destination its own wide multiplexer. This unit avoids that by stepping a position counter across the source vector. One shared multiplexer presents the element at the current position. Each destination holds only an equality comparator and loads when its index matches that position.

A single-cycle start pulse begins a sweep. The source and index vectors must stay steady while busy is high. The `LANES` parameter sets how many source positions are handled per clock, which shortens the sweep at the cost of more shared multiplexers and comparators. When the sweep ends, done pulses once. A destination whose index lies outside the source range is never written.

Top module: `gather_sweep_unit`

## Requirements
- R1: While rst_n is low and after its release, busy and done are 0 and every destination register is 0.
- R2: A start pulse sampled while idle raises busy on the next clock, and the sweep begins at source position 0.
- R3: After a sweep, destination j (bits [j*PIX_W +: PIX_W] of dst_flat) holds source element idx (bits [idx*PIX_W +: PIX_W] of src_flat), where idx is bits [j*IDX_W +: IDX_W] of idx_flat and lies in 0..SRC_N-1.
- R4: A sweep keeps busy high for exactly ceil(SRC_N/LANES) clocks: 37 clocks with one lane and 10 with four.
- R5: done is high for exactly one clock, on the clock where busy first reads low after a sweep.
- R6: A destination whose index is SRC_N or larger (37..63 by default) keeps its previous value through a sweep.
- R7: A start pulse that arrives while busy is ignored: the sweep length is unchanged and only one done pulse occurs.
- R8: While idle, the destination registers do not change, even when the source or index inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request to begin a sweep |
| src_flat | input | SRC_N*PIX_W | Packed source elements, element i at [i*PIX_W +: PIX_W] |
| idx_flat | input | DST_N*IDX_W | Packed destination indices, entry j at [j*IDX_W +: IDX_W] |
| busy | output | 1 | High while the sweep is running |
| done | output | 1 | One-cycle pulse when a sweep finishes |
| dst_flat | output | DST_N*PIX_W | Packed destination registers, entry j at [j*PIX_W +: PIX_W] |

## Verification
The index patterns are chosen so that each one catches a different class of fault.
- A modulo ramp of indices, with every source value distinct, catches any error in the position-to-element pairing.
- Indices fixed at 0 or at 36 for every destination test the first and last counter positions, where off-by-one stop logic fails.
- A mix of in-range and out-of-range indices shows whether an illegal index ever writes its register.

The bench also checks three timing cases:
- A start pulse in the middle of a sweep, to confirm it is ignored.
- Input changes while idle, to confirm the registers hold.
- A second instance with four lanes, compared against the single-lane one, to tell a correct shortened sweep from a skipped position.

// File: rtl/gather_pkg.sv
`timescale 1ns/1ps
package gather_pkg;
    function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned cnt_bits(int unsigned src_n, int unsigned lanes);
        return $clog2(src_n + lanes) + 1;
    endfunction
endpackage

// File: rtl/gather_sweep_ctrl.sv
`timescale 1ns/1ps
module gather_sweep_ctrl #(
    parameter int unsigned SRC_N = 37,
    parameter int unsigned LANES = 1,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [CNT_W-1:0] pos_base,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(LANES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SRC_N);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if ((st_q.cnt + STEP) >= LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + STEP;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_base = st_q.cnt;
    assign busy     = st_q.busy;
    assign done     = st_q.done;
endmodule

// File: rtl/gather_src_sel.sv
`timescale 1ns/1ps
module gather_src_sel #(
    parameter int unsigned SRC_N = 37,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned LANES = 1,
    parameter int unsigned CNT_W = 7
) (
    input  logic [CNT_W-1:0]       pos_base,
    input  logic                   busy,
    input  logic [SRC_N*PIX_W-1:0] src_flat,
    output logic [LANES*CNT_W-1:0] lane_pos,
    output logic [LANES-1:0]       lane_vld,
    output logic [LANES*PIX_W-1:0] lane_elem
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SRC_N);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [CNT_W-1:0] pos_d;
        logic [PIX_W-1:0] elem_d;

        always_comb begin
            pos_d  = pos_base + CNT_W'(k);
            elem_d = '0;
            for (int i = 0; i < int'(SRC_N); i++) begin
                if (pos_d == CNT_W'(i)) begin
                    elem_d = src_flat[i*PIX_W +: PIX_W];
                end
            end
        end

        assign lane_pos[k*CNT_W +: CNT_W]  = pos_d;
        assign lane_vld[k]                 = busy && (pos_d < LAST);
        assign lane_elem[k*PIX_W +: PIX_W] = elem_d;
    end
endmodule

// File: rtl/gather_dst_slot.sv
`timescale 1ns/1ps
module gather_dst_slot #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned LANES = 1,
    parameter int unsigned CNT_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       idx,
    input  logic [LANES*CNT_W-1:0] lane_pos,
    input  logic [LANES-1:0]       lane_vld,
    input  logic [LANES*PIX_W-1:0] lane_elem,
    output logic [PIX_W-1:0]       val_q
);
    logic [PIX_W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        for (int k = 0; k < int'(LANES); k++) begin
            if (lane_vld[k] && (32'(idx) == 32'(lane_pos[k*CNT_W +: CNT_W]))) begin
                val_d = lane_elem[k*PIX_W +: PIX_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end
endmodule

// File: rtl/gather_sweep_unit.sv
`timescale 1ns/1ps
module gather_sweep_unit #(
    parameter int unsigned SRC_N = 37,
    parameter int unsigned DST_N = 512,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned LANES = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SRC_N*PIX_W-1:0] src_flat,
    input  logic [DST_N*IDX_W-1:0] idx_flat,
    output logic                   busy,
    output logic                   done,
    output logic [DST_N*PIX_W-1:0] dst_flat
);
    localparam int unsigned CNT_W = gather_pkg::cnt_bits(SRC_N, LANES);

    logic [CNT_W-1:0]       pos_base;
    logic [LANES*CNT_W-1:0] lane_pos;
    logic [LANES-1:0]       lane_vld;
    logic [LANES*PIX_W-1:0] lane_elem;

    gather_sweep_ctrl #(
        .SRC_N(SRC_N), .LANES(LANES), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pos_base(pos_base), .busy(busy), .done(done)
    );

    gather_src_sel #(
        .SRC_N(SRC_N), .PIX_W(PIX_W), .LANES(LANES), .CNT_W(CNT_W)
    ) u_sel (
        .pos_base(pos_base), .busy(busy), .src_flat(src_flat),
        .lane_pos(lane_pos), .lane_vld(lane_vld), .lane_elem(lane_elem)
    );

    for (genvar j = 0; j < DST_N; j++) begin : g_dst
        gather_dst_slot #(
            .PIX_W(PIX_W), .IDX_W(IDX_W), .LANES(LANES), .CNT_W(CNT_W)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .idx(idx_flat[j*IDX_W +: IDX_W]),
            .lane_pos(lane_pos), .lane_vld(lane_vld), .lane_elem(lane_elem),
            .val_q(dst_flat[j*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/gather_sweep_chk.sv
`timescale 1ns/1ps
module gather_sweep_chk #(
    parameter int unsigned SRC_N = 37,
    parameter int unsigned DST_N = 512,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned LANES = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [DST_N*PIX_W-1:0] dst_flat
);
    localparam int unsigned SWEEP = gather_pkg::ceil_div(SRC_N, LANES);

    logic [15:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else begin
            run_len_q <= busy ? run_len_q + 16'd1 : 16'd0;
        end
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R4 and R7: a sweep lasts its full length even if start is pulsed again
    a_r4_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len_q == 16'(SWEEP)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(dst_flat));
endmodule

bind gather_sweep_unit gather_sweep_chk #(
    .SRC_N(SRC_N), .DST_N(DST_N), .PIX_W(PIX_W), .LANES(LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .dst_flat(dst_flat)
);

// File: tb/gather_sweep_unit_bench.sv
`timescale 1ns/1ps
module gather_sweep_unit_bench;
    localparam int SRC_N = 37;
    localparam int DST_N = 512;
    localparam int PIX_W = 8;
    localparam int IDX_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PIX_W-1:0] src_m [SRC_N];
    logic [IDX_W-1:0] idx_m [DST_N];
    logic [PIX_W-1:0] exp_m [DST_N];
    logic [SRC_N*PIX_W-1:0] src_flat;
    logic [DST_N*IDX_W-1:0] idx_flat;
    logic busy1, done1, busy4, done4;
    logic [DST_N*PIX_W-1:0] dst1, dst4;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < SRC_N; i++) src_flat[i*PIX_W +: PIX_W] = src_m[i];
        for (int j = 0; j < DST_N; j++) idx_flat[j*IDX_W +: IDX_W] = idx_m[j];
    end

    gather_sweep_unit u_gather_sweep_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .src_flat(src_flat),
        .idx_flat(idx_flat), .busy(busy1), .done(done1), .dst_flat(dst1)
    );

    gather_sweep_unit #(.LANES(4)) u_quad (
        .clk(clk), .rst_n(rst_n), .start(start), .src_flat(src_flat),
        .idx_flat(idx_flat), .busy(busy4), .done(done4), .dst_flat(dst4)
    );

    task automatic compare(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_bank(string req);
        int bad1 = 0;
        int bad4 = 0;
        for (int j = 0; j < DST_N; j++) begin
            if (dst1[j*PIX_W +: PIX_W] !== exp_m[j]) begin
                bad1++;
                if (bad1 == 1) compare({req, " lane1 dst"}, int'(dst1[j*PIX_W +: PIX_W]), int'(exp_m[j]));
            end
            if (dst4[j*PIX_W +: PIX_W] !== exp_m[j]) begin
                bad4++;
                if (bad4 == 1) compare({req, " lane4 dst"}, int'(dst4[j*PIX_W +: PIX_W]), int'(exp_m[j]));
            end
        end
        if (bad1 == 0) compare({req, " lane1 bank"}, 0, 0);
        if (bad4 == 0) compare({req, " lane4 bank"}, 0, 0);
    endtask

    task automatic fill_src(int seed);
        for (int i = 0; i < SRC_N; i++) src_m[i] = PIX_W'(seed * 7 + i * 13 + 1);
    endtask

    task automatic update_model();
        for (int j = 0; j < DST_N; j++)
            if (int'(idx_m[j]) < SRC_N) exp_m[j] = src_m[idx_m[j]];
    endtask

    task automatic run_sweep(string req, bit poke_mid);
        int nb1 = 0, nb4 = 0, nd1 = 0, nd4 = 0, first_busy = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_busy = int'(busy1);
        for (int c = 0; c < 60; c++) begin
            if (busy1) nb1++;
            if (busy4) nb4++;
            if (done1) nd1++;
            if (done4) nd4++;
            @(negedge clk);
            start = poke_mid && (c == 4);
        end
        start = 1'b0;
        compare({req, " R2 busy after start"}, first_busy, 1);
        compare({req, " R4 lane1 length"}, nb1, 37);
        compare({req, " R4 lane4 length"}, nb4, 10);
        compare({req, " R5 lane1 done count"}, nd1, 1);
        compare({req, " R5 lane4 done count"}, nd4, 1);
        update_model();
    endtask

    task automatic t_reset();
        compare("R1 busy", int'(busy1), 0);
        compare("R1 done", int'(done1), 0);
        for (int j = 0; j < DST_N; j++) exp_m[j] = '0;
        check_bank("R1 reset");
    endtask

    task automatic t_ramp();
        fill_src(3);
        for (int j = 0; j < DST_N; j++) idx_m[j] = IDX_W'(j % SRC_N);
        run_sweep("ramp", 1'b0);
        check_bank("R3 ramp");
    endtask

    task automatic t_edges();
        fill_src(11);
        for (int j = 0; j < DST_N; j++) idx_m[j] = (j % 2 == 0) ? IDX_W'(0) : IDX_W'(36);
        run_sweep("edges", 1'b0);
        check_bank("R3 first/last position");
    endtask

    task automatic t_out_of_range();
        fill_src(29);
        for (int j = 0; j < DST_N; j++) idx_m[j] = (j % 3 == 0) ? IDX_W'(37 + j % 27) : IDX_W'((j * 5) % SRC_N);
        run_sweep("range", 1'b0);
        check_bank("R6 illegal index kept");
    endtask

    task automatic t_restart_ignored();
        fill_src(41);
        for (int j = 0; j < DST_N; j++) idx_m[j] = IDX_W'((j * 7 + 3) % SRC_N);
        run_sweep("R7 mid start", 1'b1);
        check_bank("R7 bank after ignored start");
    endtask

    task automatic t_idle_hold();
        fill_src(77);
        for (int j = 0; j < DST_N; j++) idx_m[j] = IDX_W'((j + 9) % SRC_N);
        repeat (6) @(negedge clk);
        compare("R8 still idle", int'(busy1), 0);
        check_bank("R8 idle hold");
    endtask

    initial begin
        for (int i = 0; i < SRC_N; i++) src_m[i] = '0;
        for (int j = 0; j < DST_N; j++) idx_m[j] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ramp();
        t_edges();
        t_out_of_range();
        t_restart_ignored();
        t_idle_hold();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule